// File: doc/BRIEF.md
# Post-Entry Guest Event Arbiter

This block picks which pending guest event is serviced next once a virtual-machine entry has completed. Eleven sources can request service. They include platform signals (INIT, SMI), exit sources (TPR threshold, monitor trap, preemption timer, NMI window, interrupt window), a pending debug trap, and the interrupt classes (NMI, virtual interrupt, external interrupt). Each request is latched as pending and stays pending until its consumer acknowledges it. Every cycle the block issues at most one registered one-hot grant to the highest ranked source that is eligible.

A source's eligibility depends on the processor's activity state after entry and on the relevant control bits. Nothing is granted until the injection-done input is high, so every post-entry event follows any event injected by the entry. When the debug trap wins, two registered flags tell the consumer whether it becomes a VM exit or a DR6 update. The choice comes from bit 1 of the exception bitmap. A one-cycle wake pulse is raised when an interrupt-window or virtual-interrupt grant is newly issued while the processor sits in HLT.

Top module: `guest_event_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `grant`, `dbg_to_exit`, `dbg_to_dr6` and `hlt_wake` are all 0, and no request is pending.
- R2: When `inj_done` is low at a clock edge, `grant` is 0 after that edge. Pending requests are kept and are granted once `inj_done` is high again.
- R3: The grant bit positions and their ranking, highest first, are: 0 INIT, 1 SMI, 2 TPR-threshold exit, 3 monitor-trap exit, 4 debug trap, 5 preemption-timer exit, 6 NMI, 7 NMI-window exit, 8 interrupt-window exit, 9 virtual interrupt, 10 external interrupt. The eligible pending source with the lowest index is granted.
- R4: At most one `grant` bit is high in any cycle.
- R5: An `evt_req` bit sets that source's pending bit. An `evt_ack` bit clears it unless the same source requests again in that cycle. The grant computed at that edge already skips the acknowledged source, so a debug trap acknowledged while a timer exit is pending hands the grant to the timer on the next cycle.
- R6: The NMI-window exit is eligible only when `nmiwin_exit_en` is 1. The interrupt-window exit is eligible only when `iwin_exit_en` is 1. The virtual interrupt is eligible only when `iwin_exit_en` is 0 and `vint_dlv_en` is 1. The timer exit is eligible only when `tmr_en` is 1 and the activity state is not wait-for-SIPI.
- R7: Activity state encoding is 0 active, 1 HLT, 2 shutdown, 3 wait-for-SIPI. In shutdown and wait-for-SIPI, neither interrupt-window exits nor virtual interrupts are granted.
- R8: `hlt_wake` is high for one cycle together with a grant of bit 8 or bit 9 that was not granted in the cycle before, when the activity state is HLT. It is low otherwise.
- R9: With a debug-trap grant, `dbg_to_exit` follows bit 1 of `xcp_bitmap` and `dbg_to_dr6` is its inverse. Both flags are 0 when the debug trap is not granted.
- R10: The debug trap is eligible only while `dbg_vld` is high. Without it, lower-ranked pending sources are granted instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_done | input | 1 | Entry event injection finished; enables grants |
| evt_req | input | 11 | Per-source request, sets pending |
| evt_ack | input | 11 | Per-source acknowledge, clears pending |
| dbg_vld | input | 1 | Pending debug trap is valid |
| act_state | input | 2 | Activity state after entry |
| iwin_exit_en | input | 1 | Interrupt-window exiting control |
| vint_dlv_en | input | 1 | Virtual-interrupt delivery control |
| nmiwin_exit_en | input | 1 | NMI-window exiting control |
| tmr_en | input | 1 | Preemption timer active control |
| xcp_bitmap | input | 32 | Exception bitmap; bit 1 selects debug exit |
| grant | output | 11 | Registered one-hot grant |
| dbg_to_exit | output | 1 | Debug grant becomes a VM exit |
| dbg_to_dr6 | output | 1 | Debug grant updates DR6 |
| hlt_wake | output | 1 | Wake-from-HLT pulse |

## Verification
The hardest case to reach from the ports is a handover between ranked neighbours. One example is the debug trap being acknowledged in the very cycle that a timer exit is pending. Another is a virtual interrupt winning in HLT only after every higher source has drained. Sparse random requests alone seldom line these up. The bench therefore runs directed sequences that load several sources while `inj_done` is low, release them together, and acknowledge grants one by one. Random phases with acknowledges biased toward the current grant then cycle through the control bits and activity states.

// File: rtl/gea_pkg.sv
package gea_pkg;
  localparam int NSRC = 11;
  localparam int SRC_INIT   = 0;
  localparam int SRC_SMI    = 1;
  localparam int SRC_TPR    = 2;
  localparam int SRC_MTRAP  = 3;
  localparam int SRC_DBG    = 4;
  localparam int SRC_TMR    = 5;
  localparam int SRC_NMI    = 6;
  localparam int SRC_NMIWIN = 7;
  localparam int SRC_IWIN   = 8;
  localparam int SRC_VINT   = 9;
  localparam int SRC_EXT    = 10;

  typedef enum logic [1:0] {
    ACT_RUN  = 2'd0,
    ACT_HLT  = 2'd1,
    ACT_SHUT = 2'd2,
    ACT_SIPI = 2'd3
  } act_e;
endpackage

// File: rtl/gea_pend.sv
module gea_pend #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_d,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // a new request in the same cycle outranks the acknowledge
    assign pend_d[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);
    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_d[i];
    end
  end
endmodule

// File: rtl/gea_elig.sv
module gea_elig
  import gea_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic            inj_done,
  input  logic            dbg_vld,
  input  logic [1:0]      act_state,
  input  logic            iwin_exit_en,
  input  logic            vint_dlv_en,
  input  logic            nmiwin_exit_en,
  input  logic            tmr_en,
  output logic [NSRC-1:0] elig
);
  logic idle_dead;
  logic [NSRC-1:0] enab;

  assign idle_dead = (act_state == ACT_SHUT) || (act_state == ACT_SIPI);

  always_comb begin
    enab = '1;
    enab[SRC_DBG]    = dbg_vld;
    enab[SRC_TMR]    = tmr_en && (act_state != ACT_SIPI);
    enab[SRC_NMIWIN] = nmiwin_exit_en;
    enab[SRC_IWIN]   = iwin_exit_en && !idle_dead;
    enab[SRC_VINT]   = !iwin_exit_en && vint_dlv_en && !idle_dead;
    elig = inj_done ? (pend & enab) : '0;
  end
endmodule

// File: rtl/gea_prio.sv
module gea_prio #(
  parameter int N = 11
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot
);
  // lowest index ranks highest
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rank
    assign onehot[i]  = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/guest_event_arbiter.sv
module guest_event_arbiter
  import gea_pkg::*;
#(
  parameter int XBMP_W = 32,
  parameter int DB_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inj_done,
  input  logic [NSRC-1:0]   evt_req,
  input  logic [NSRC-1:0]   evt_ack,
  input  logic              dbg_vld,
  input  logic [1:0]        act_state,
  input  logic              iwin_exit_en,
  input  logic              vint_dlv_en,
  input  logic              nmiwin_exit_en,
  input  logic              tmr_en,
  input  logic [XBMP_W-1:0] xcp_bitmap,
  output logic [NSRC-1:0]   grant,
  output logic              dbg_to_exit,
  output logic              dbg_to_dr6,
  output logic              hlt_wake
);
  logic [NSRC-1:0] pend_d, pend_q, elig, pick;
  logic            wake_d, db_sel;

  gea_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(evt_req), .clr_i(evt_ack),
    .pend_d(pend_d), .pend_q(pend_q)
  );

  gea_elig u_elig (
    .pend(pend_d), .inj_done(inj_done), .dbg_vld(dbg_vld),
    .act_state(act_state), .iwin_exit_en(iwin_exit_en),
    .vint_dlv_en(vint_dlv_en), .nmiwin_exit_en(nmiwin_exit_en),
    .tmr_en(tmr_en), .elig(elig)
  );

  gea_prio #(.N(NSRC)) u_prio (.req(elig), .onehot(pick));

  assign db_sel = xcp_bitmap[DB_BIT];
  assign wake_d = (act_state == ACT_HLT) &&
                  ((pick[SRC_IWIN] && !grant[SRC_IWIN]) ||
                   (pick[SRC_VINT] && !grant[SRC_VINT]));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      dbg_to_exit <= 1'b0;
      dbg_to_dr6  <= 1'b0;
      hlt_wake    <= 1'b0;
    end else begin
      grant       <= pick;
      dbg_to_exit <= pick[SRC_DBG] && db_sel;
      dbg_to_dr6  <= pick[SRC_DBG] && !db_sel;
      hlt_wake    <= wake_d;
    end
  end
endmodule

// File: rtl/gea_chk.sv
module gea_chk
  import gea_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            inj_done,
  input logic [NSRC-1:0] evt_req,
  input logic [NSRC-1:0] evt_ack,
  input logic [1:0]      act_state,
  input logic            iwin_exit_en,
  input logic [NSRC-1:0] grant,
  input logic            dbg_to_exit,
  input logic            dbg_to_dr6,
  input logic            hlt_wake
);
  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R2
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !inj_done |=> (grant == '0));
  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant & $past(evt_ack & ~evt_req)) == '0));
  // R6
  iwin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !iwin_exit_en |=> !grant[SRC_IWIN]);
  // R7
  dead_block_chk: assert property (@(posedge clk) disable iff (rst)
    (act_state == ACT_SHUT || act_state == ACT_SIPI) |=>
      !(grant[SRC_IWIN] || grant[SRC_VINT]));
  // R9
  dbg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_to_exit || dbg_to_dr6) |-> (grant[SRC_DBG] && !(dbg_to_exit && dbg_to_dr6)));
  // R8
  wake_src_chk: assert property (@(posedge clk) disable iff (rst)
    hlt_wake |-> (grant[SRC_IWIN] || grant[SRC_VINT]));
endmodule

bind guest_event_arbiter gea_chk u_chk (
  .clk(clk), .rst(rst), .inj_done(inj_done), .evt_req(evt_req),
  .evt_ack(evt_ack), .act_state(act_state), .iwin_exit_en(iwin_exit_en),
  .grant(grant), .dbg_to_exit(dbg_to_exit), .dbg_to_dr6(dbg_to_dr6),
  .hlt_wake(hlt_wake)
);

// File: tb/sim_guest_event_arbiter.sv
module sim_guest_event_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inj_done = 1'b0;
  logic [N-1:0] evt_req = '0, evt_ack = '0;
  logic dbg_vld = 1'b0;
  logic [1:0] act_state = 2'd0;
  logic iwin_exit_en = 1'b0, vint_dlv_en = 1'b0, nmiwin_exit_en = 1'b0, tmr_en = 1'b0;
  logic [31:0] xcp_bitmap = '0;
  logic [N-1:0] grant;
  logic dbg_to_exit, dbg_to_dr6, hlt_wake;

  int checks = 0, errors = 0;
  logic [N-1:0] m_pend = '0, m_grant = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guest_event_arbiter u0 (
    .clk(clk), .rst(rst), .inj_done(inj_done), .evt_req(evt_req),
    .evt_ack(evt_ack), .dbg_vld(dbg_vld), .act_state(act_state),
    .iwin_exit_en(iwin_exit_en), .vint_dlv_en(vint_dlv_en),
    .nmiwin_exit_en(nmiwin_exit_en), .tmr_en(tmr_en),
    .xcp_bitmap(xcp_bitmap), .grant(grant), .dbg_to_exit(dbg_to_exit),
    .dbg_to_dr6(dbg_to_dr6), .hlt_wake(hlt_wake)
  );

  function automatic logic allowed(int s);
    case (s)
      4:  return dbg_vld;
      5:  return tmr_en && act_state != 2'd3;
      7:  return nmiwin_exit_en;
      8:  return iwin_exit_en && act_state < 2'd2;
      9:  return !iwin_exit_en && vint_dlv_en && act_state < 2'd2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [N-1:0] expect_grant(logic [N-1:0] p);
    logic [N-1:0] g = '0;
    if (!inj_done) return g;
    for (int s = 0; s < N; s++)
      if (p[s] && allowed(s)) begin g[s] = 1'b1; return g; end
    return g;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: model inputs, clock edge, then compare
  task automatic step(string tag);
    logic [N-1:0] np, eg;
    logic ew, ex, ed;
    np = (m_pend & ~evt_ack) | evt_req;
    eg = expect_grant(np);
    ex = eg[4] && xcp_bitmap[1];
    ed = eg[4] && !xcp_bitmap[1];
    ew = (act_state == 2'd1) && ((eg[8] && !m_grant[8]) || (eg[9] && !m_grant[9]));
    @(posedge clk); #1;
    m_pend = np; m_grant = eg;
    check(tag, 32'(grant), 32'(eg));
    check({tag, "/dbgflags"}, {30'd0, dbg_to_exit, dbg_to_dr6}, {30'd0, ex, ed});
    check({tag, "/wake R8"}, 32'(hlt_wake), 32'(ew));
    check("R4 onehot", 32'($countones(grant) <= 1), 32'd1);
  endtask

  task automatic idle_inputs();
    evt_req = '0; evt_ack = '0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset grant", 32'(grant), 0);
    check("R1 reset flags", {29'd0, dbg_to_exit, dbg_to_dr6, hlt_wake}, 0);
    rst = 1'b0;
    step("R1 first cycle");

    // R2: load many while injection pending
    evt_req = 11'h7FF; dbg_vld = 1; tmr_en = 1; nmiwin_exit_en = 1;
    step("R2 held");
    idle_inputs();
    step("R2 held still");
    inj_done = 1;
    // R3: drain in rank order by acknowledging each grant
    for (int k = 0; k < 12; k++) begin
      evt_ack = m_grant;
      xcp_bitmap[1] = k[0];
      step("R3 drain");
    end
    idle_inputs();

    // R5: debug acknowledged while timer pending
    evt_req = 11'b00000110000; xcp_bitmap = 32'h2;
    step("R9 debug exit");
    evt_req = '0; evt_ack = 11'b00000010000;
    step("R5 timer after debug");
    evt_ack = 11'b00000100000;
    step("R5 timer acked");
    evt_ack = '0;

    // R10: debug not valid, NMI wins
    dbg_vld = 0; evt_req = 11'b00001010000;
    step("R10 invalid debug");
    evt_req = '0; dbg_vld = 1; xcp_bitmap = 0;
    step("R10 debug becomes valid R9 dr6");
    evt_ack = 11'b00001010000;
    step("R5 clear");
    evt_ack = '0;

    // R6/R7/R8: virtual interrupt in HLT vs shutdown
    act_state = 2'd2; iwin_exit_en = 0; vint_dlv_en = 1; evt_req = 11'b01000000000;
    step("R7 vint blocked in shutdown");
    evt_req = '0; act_state = 2'd1;
    step("R8 vint wakes HLT");
    step("R8 no second pulse");
    iwin_exit_en = 1;
    step("R6 vint off with iwin exiting");
    evt_req = 11'b00100000000;
    step("R8 iwin wakes HLT");
    act_state = 2'd3; evt_req = 11'b00000100000;
    step("R7 R6 sipi blocks iwin and timer");
    act_state = 2'd0; evt_ack = 11'h7FF; evt_req = '0;
    step("R5 flush");
    evt_ack = '0;

    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      evt_req = ($urandom % 4 == 0) ? 11'(1 << ($urandom % N)) : '0;
      evt_ack = (r[3:0] < 4'd6) ? m_grant : ((r[5:4] == 0) ? 11'($urandom) : '0);
      if (r[11:8] == 0) begin
        act_state = 2'($urandom); iwin_exit_en = r[12]; vint_dlv_en = r[13];
        nmiwin_exit_en = r[14]; tmr_en = r[15]; dbg_vld = r[16];
      end
      inj_done = (r[23:20] != 0);
      xcp_bitmap = {$urandom} & 32'h0000_00FF;
      step("R3 random");
    end

    rst = 1'b1; idle_inputs();
    @(posedge clk); #1;
    check("R1 reset again", 32'(grant), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule